// File: doc/BRIEF.md
# Indirect Controller Register Bridge

This block places one 64-bit command word in front of a small bank of 8-bit controller registers. The host cannot reach those registers directly. To access one, it writes the whole command word with the top bit set. That word carries an opcode, a direction flag, a register selector and a data byte. The bridge then owns the word for a fixed number of clock cycles and performs the register access. When the access is done, it clears the top bit. On a read, the fetched byte is placed in the low byte of the same word. Software learns that the access has finished by polling the top bit.

Every field that the bridge does not act on is kept exactly as the host wrote it and can be read back. These fields are an extended-address flag, a size override, a size field, a target address and an internal address. Only the extended opcode reaches the register bank. Every other opcode runs through the same timed sequence, but no register changes.

The control and clock-configuration registers drive outputs toward the serial engine. The status register is a read-only view of an input that the engine supplies.

Top module: `ind_reg_bridge`

## Requirements
- R1: After a synchronous reset the command word reads as zero, and both the control output and the clock-configuration output are zero.
- R2: A host write while bit 63 is clear stores all 64 bits. If the written bit 63 is 0, the word reads back exactly as written and no register changes.
- R3: A host write with bit 63 set starts an access. Bit 63 reads as 1 for exactly LATENCY (default 2) cycles after the capturing edge and then reads 0.
- R4: With opcode bits 60:57 = 6 (extended), bit 56 = 0 and selector bits 34:32 = 1, completion loads bits 7:0 into the data register. A later read with selector 1 returns that byte.
- R5: An extended write with selector 2 loads the control register, which appears on `ctl_out` from the completion edge. An extended read with selector 2 returns it.
- R6: An extended write with selector 3 loads the clock-configuration register (`clk_cfg_out`). An extended read with selector 3 returns `stat_in` instead of that register.
- R7: An extended write with selector 7 returns the data and control registers to zero and leaves clock configuration unchanged.
- R8: An extended read (bit 56 = 1) replaces bits 7:0 with the selected byte. Bits 62:8 keep the values the host wrote.
- R9: A host write arriving while bit 63 is set is ignored, including one sampled on the completion edge. The finished access's word remains readable.
- R10: Opcodes other than 6 complete after the same delay with no register effect. Only bit 63 of the word changes, even when bit 56 is 1.
- R11: An extended read of selector 0, 4, 5, 6 or 7 returns 0 in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word (poll bit 63) |
| stat_in | input | 8 | Status byte supplied by the serial engine |
| ctl_out | output | 8 | Control register contents |
| clk_cfg_out | output | 8 | Clock-configuration register contents |

## Verification
Two events can land on the same edge: a new host write and the completion of the access already in flight. The bench holds a second, different command word on the host port during the final cycle of an access, so that it is sampled exactly on the completion edge. The check then expects the finished word with bit 63 clear and the second word discarded. A behavioural model, compared on every clock, confirms that the next write after that edge is accepted normally.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    localparam int CMD_W     = 64;
    localparam int BYTE_W    = 8;
    localparam int VLD_BIT   = 63;
    localparam int RD_BIT    = 56;
    localparam int OP_LSB    = 57;
    localparam int OP_W      = 4;
    localparam int SEL_LSB   = 32;
    localparam int SEL_W     = 3;

    localparam logic [BYTE_W-1:0] DATA_RST = 8'h00;
    localparam logic [BYTE_W-1:0] CTL_RST  = 8'h00;
    localparam logic [BYTE_W-1:0] CLK_RST  = 8'h00;

    typedef enum logic [OP_W-1:0] {
        OPC_ADDR7     = 4'd0,
        OPC_ADDR7_IA  = 4'd1,
        OPC_ADDR10    = 4'd2,
        OPC_ADDR10_IA = 4'd3,
        OPC_CLKSETUP  = 4'd4,
        OPC_EXTENDED  = 4'd6
    } opcode_e;

    typedef enum logic [SEL_W-1:0] {
        RSEL_NONE  = 3'd0,
        RSEL_DATA  = 3'd1,
        RSEL_CTL   = 3'd2,
        RSEL_CLK   = 3'd3,
        RSEL_SRST  = 3'd7
    } regsel_e;

    typedef struct packed {
        logic              valid;
        logic              rd;
        logic [OP_W-1:0]   op;
        logic [SEL_W-1:0]  sel;
        logic [BYTE_W-1:0] wbyte;
    } cmd_fields_t;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [SEL_W-1:0]  sel;
        logic [BYTE_W-1:0] wdata;
    } ireq_t;

    function automatic cmd_fields_t split_cmd(input logic [CMD_W-1:0] w);
        cmd_fields_t f;
        f.valid = w[VLD_BIT];
        f.rd    = w[RD_BIT];
        f.op    = w[OP_LSB +: OP_W];
        f.sel   = w[SEL_LSB +: SEL_W];
        f.wbyte = w[BYTE_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
    import ibr_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    output cmd_fields_t      fields_o,
    output logic             is_ext_o
);

    always_comb begin
        fields_o = split_cmd(cmd_i);
        is_ext_o = (fields_o.op == OPC_EXTENDED);
    end

endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [CMD_W-1:0]  host_wdata,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [CMD_W-1:0]  cmd_o,
    output ireq_t             req_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LATENCY - 1);

    logic [CMD_W-1:0] cmd_q;
    logic [CNT_W-1:0] cnt_q;
    cmd_fields_t      fld;
    logic             is_ext;
    logic             last;

    ibr_decode u_dec (
        .cmd_i    (cmd_q),
        .fields_o (fld),
        .is_ext_o (is_ext)
    );

    always_comb begin
        last        = fld.valid && (cnt_q == LAST_CNT);
        req_o.we    = last && is_ext && !fld.rd;
        req_o.re    = last && is_ext && fld.rd;
        req_o.sel   = fld.sel;
        req_o.wdata = fld.wbyte;
    end

    assign cmd_o  = cmd_q;
    assign busy_o = fld.valid;
    assign done_o = last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            cnt_q <= '0;
        end else if (fld.valid) begin
            if (last) begin
                cmd_q[VLD_BIT] <= 1'b0;
                cnt_q          <= '0;
                if (req_o.re) begin
                    cmd_q[BYTE_W-1:0] <= rdata_i;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (host_we) begin
            cmd_q <= host_wdata;
            cnt_q <= '0;
        end
    end

    // Fields above the data byte may not move while an access owns the word.
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(cmd_q[VLD_BIT-1:BYTE_W]));

    assert_done_clears_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    assert_plain_op_byte_R10: assert property (@(posedge clk) disable iff (rst)
        (done_o && !is_ext) |=> $stable(cmd_q[BYTE_W-1:0]));

endmodule

// File: rtl/ibr_regbank.sv
module ibr_regbank
    import ibr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ireq_t             req_i,
    input  logic [BYTE_W-1:0] stat_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [BYTE_W-1:0] ctl_o,
    output logic [BYTE_W-1:0] clk_o
);

    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] ctl_q;
    logic [BYTE_W-1:0] clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= DATA_RST;
            ctl_q  <= CTL_RST;
            clk_q  <= CLK_RST;
        end else if (req_i.we) begin
            case (req_i.sel)
                RSEL_DATA: data_q <= req_i.wdata;
                RSEL_CTL:  ctl_q  <= req_i.wdata;
                RSEL_CLK:  clk_q  <= req_i.wdata;
                RSEL_SRST: begin
                    data_q <= DATA_RST;
                    ctl_q  <= CTL_RST;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (req_i.sel)
            RSEL_DATA: rdata_o = data_q;
            RSEL_CTL:  rdata_o = ctl_q;
            RSEL_CLK:  rdata_o = stat_i;
            default:   rdata_o = '0;
        endcase
    end

    assign ctl_o = ctl_q;
    assign clk_o = clk_q;

    assert_srst_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (req_i.we && req_i.sel == RSEL_SRST) |=> (data_q == DATA_RST && ctl_q == CTL_RST));

    assert_srst_keeps_clk_R7: assert property (@(posedge clk) disable iff (rst)
        (req_i.we && req_i.sel == RSEL_SRST) |=> $stable(clk_q));

    assert_read_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        (req_i.re && !req_i.we) |=> ($stable(data_q) && $stable(ctl_q) && $stable(clk_q)));

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import ibr_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [63:0] host_wdata,
    output logic [63:0] host_rdata,
    input  logic [7:0]  stat_in,
    output logic [7:0]  ctl_out,
    output logic [7:0]  clk_cfg_out
);

    ireq_t             ireq;
    logic [BYTE_W-1:0] irdata;
    logic              busy;
    logic              done;

    ibr_seq #(.LATENCY(LATENCY)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .rdata_i    (irdata),
        .cmd_o      (host_rdata),
        .req_o      (ireq),
        .busy_o     (busy),
        .done_o     (done)
    );

    ibr_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .req_i   (ireq),
        .stat_i  (stat_in),
        .rdata_o (irdata),
        .ctl_o   (ctl_out),
        .clk_o   (clk_cfg_out)
    );

    // A host write that lands while busy must leave the polled flag set for the next cycle.
    assert_ignore_write_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && host_we) |=> host_rdata[VLD_BIT]);

endmodule

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;

    localparam int LAT = 2;
    localparam logic [63:0] PADMASK = 64'h20FF_FF00_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic [7:0]  stat_in = 8'h5A;
    logic [7:0]  ctl_out;
    logic [7:0]  clk_cfg_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    ind_reg_bridge #(.LATENCY(LAT)) u_ind_reg_bridge (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .stat_in     (stat_in),
        .ctl_out     (ctl_out),
        .clk_cfg_out (clk_cfg_out)
    );

    always #5 clk = ~clk;

    // Behavioural reference model, advanced on every rising edge.
    logic [63:0] m_cmd;
    int          m_cnt;
    logic [7:0]  m_data, m_ctl, m_clk;

    always @(posedge clk) begin
        if (rst) begin
            m_cmd = '0; m_cnt = 0; m_data = 0; m_ctl = 0; m_clk = 0;
        end else if (m_cmd[63]) begin
            if (m_cnt == LAT - 1) begin
                if (m_cmd[60:57] == 4'd6) begin
                    if (m_cmd[56]) begin
                        m_cmd[7:0] = (m_cmd[34:32] == 3'd1) ? m_data :
                                     (m_cmd[34:32] == 3'd2) ? m_ctl  :
                                     (m_cmd[34:32] == 3'd3) ? stat_in : 8'h00;
                    end else begin
                        if (m_cmd[34:32] == 3'd1) m_data = m_cmd[7:0];
                        if (m_cmd[34:32] == 3'd2) m_ctl  = m_cmd[7:0];
                        if (m_cmd[34:32] == 3'd3) m_clk  = m_cmd[7:0];
                        if (m_cmd[34:32] == 3'd7) begin m_data = 0; m_ctl = 0; end
                    end
                end
                m_cmd[63] = 1'b0;
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end else if (host_we) begin
            m_cmd = host_wdata;
            m_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(host_rdata == m_cmd, "R3 model word", host_rdata, m_cmd);
            chk(ctl_out == m_ctl, "R5 model ctl", {56'h0, ctl_out}, {56'h0, m_ctl});
            chk(clk_cfg_out == m_clk, "R6 model clk", {56'h0, clk_cfg_out}, {56'h0, m_clk});
        end
    end

    function automatic logic [63:0] mk(input logic [3:0] op, input logic rd, input logic [2:0] sel,
                                       input logic [7:0] b, input logic [63:0] pad);
        logic [63:0] w;
        w = pad & PADMASK;
        w[63] = 1'b1;
        w[60:57] = op;
        w[56] = rd;
        w[34:32] = sel;
        w[7:0] = b;
        return w;
    endfunction

    function automatic logic [63:0] done_word(input logic [63:0] w, input logic [7:0] b);
        logic [63:0] r;
        r = w;
        r[63] = 1'b0;
        r[7:0] = b;
        return r;
    endfunction

    task automatic host_write(input logic [63:0] w);
        host_we = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Called at a negedge; returns at the negedge after completion.
    task automatic run_access(input logic [63:0] w, output logic [63:0] res);
        host_write(w);
        for (int i = 0; i < LAT; i++) begin
            chk(host_rdata[63] == 1'b1, "R3 valid held", {63'h0, host_rdata[63]}, 64'h1);
            @(negedge clk);
        end
        chk(host_rdata[63] == 1'b0, "R3 valid cleared", {63'h0, host_rdata[63]}, 64'h0);
        res = host_rdata;
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [63:0] w, res;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(host_rdata == 64'h0, "R1 word", host_rdata, 64'h0);
        chk(ctl_out == 8'h0 && clk_cfg_out == 8'h0, "R1 outputs", {48'h0, ctl_out, clk_cfg_out}, 64'h0);

        // R2: plain store without valid
        w = 64'h7234_5678_9ABC_DEF0;
        host_write(w);
        chk(host_rdata == w, "R2 store", host_rdata, w);
        repeat (3) @(negedge clk);
        chk(host_rdata == w && ctl_out == 8'h0, "R2 no access", host_rdata, w);

        // R4: write data register
        w = mk(4'd6, 1'b0, 3'd1, 8'h3C, 64'hFFFF_FFFF_FFFF_FFFF);
        run_access(w, res);
        chk(res == done_word(w, 8'h3C), "R4 write word", res, done_word(w, 8'h3C));

        // R5: write control
        w = mk(4'd6, 1'b0, 3'd2, 8'hC4, 64'h0123_4567_89AB_CDEF);
        run_access(w, res);
        chk(ctl_out == 8'hC4, "R5 ctl out", {56'h0, ctl_out}, 64'hC4);

        // R6: write clock config
        w = mk(4'd6, 1'b0, 3'd3, 8'h17, 64'h0);
        run_access(w, res);
        chk(clk_cfg_out == 8'h17, "R6 clk out", {56'h0, clk_cfg_out}, 64'h17);

        // R4 / R8: read data back, upper fields preserved
        w = mk(4'd6, 1'b1, 3'd1, 8'hEE, 64'hA5A5_A5A5_5A5A_5A5A);
        run_access(w, res);
        chk(res == done_word(w, 8'h3C), "R8 read data", res, done_word(w, 8'h3C));

        // R5: read control
        w = mk(4'd6, 1'b1, 3'd2, 8'h00, 64'h2000_0000_0000_0000);
        run_access(w, res);
        chk(res[7:0] == 8'hC4, "R5 read ctl", {56'h0, res[7:0]}, 64'hC4);

        // R6: selector 3 read returns status input
        w = mk(4'd6, 1'b1, 3'd3, 8'h00, 64'h0);
        run_access(w, res);
        chk(res[7:0] == 8'h5A, "R6 read status", {56'h0, res[7:0]}, 64'h5A);
        stat_in = 8'hB3;
        run_access(w, res);
        chk(res[7:0] == 8'hB3, "R6 status follows", {56'h0, res[7:0]}, 64'hB3);

        // R11: unassigned selectors read zero
        w = mk(4'd6, 1'b1, 3'd5, 8'hFF, 64'h0);
        run_access(w, res);
        chk(res[7:0] == 8'h00, "R11 sel5", {56'h0, res[7:0]}, 64'h0);
        w = mk(4'd6, 1'b1, 3'd0, 8'hFF, 64'h0);
        run_access(w, res);
        chk(res[7:0] == 8'h00, "R11 sel0", {56'h0, res[7:0]}, 64'h0);

        // R10: non-extended opcodes
        w = mk(4'd4, 1'b0, 3'd2, 8'h99, 64'hFFFF_0000_FFFF_0000);
        run_access(w, res);
        chk(res == done_word(w, 8'h99) && ctl_out == 8'hC4, "R10 clk setup op", res, done_word(w, 8'h99));
        w = mk(4'd0, 1'b1, 3'd1, 8'h77, 64'h0);
        run_access(w, res);
        chk(res[7:0] == 8'h77, "R10 addr op read", {56'h0, res[7:0]}, 64'h77);

        // R7: soft reset
        w = mk(4'd6, 1'b0, 3'd7, 8'h55, 64'h0);
        run_access(w, res);
        chk(ctl_out == 8'h00, "R7 ctl cleared", {56'h0, ctl_out}, 64'h0);
        chk(clk_cfg_out == 8'h17, "R7 clk kept", {56'h0, clk_cfg_out}, 64'h17);
        w = mk(4'd6, 1'b1, 3'd1, 8'hAA, 64'h0);
        run_access(w, res);
        chk(res[7:0] == 8'h00, "R7 data cleared", {56'h0, res[7:0]}, 64'h0);

        // R9: second write held across the completion edge is dropped
        w = mk(4'd6, 1'b0, 3'd2, 8'h81, 64'h1111_2222_3333_4444);
        host_write(w);
        host_we = 1'b1;
        host_wdata = mk(4'd6, 1'b0, 3'd2, 8'h42, 64'h0);
        repeat (LAT) @(negedge clk);
        host_we = 1'b0;
        chk(host_rdata == done_word(w, 8'h81), "R9 collision word", host_rdata, done_word(w, 8'h81));
        chk(ctl_out == 8'h81, "R9 collision ctl", {56'h0, ctl_out}, 64'h81);
        // next write accepted
        w = mk(4'd6, 1'b0, 3'd2, 8'h42, 64'h0);
        run_access(w, res);
        chk(ctl_out == 8'h42, "R9 next accepted", {56'h0, ctl_out}, 64'h42);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

endmodule